// File: doc/BRIEF.md
# Serial Pattern Error-Rate Checker

This block checks a received serial bit stream against a reference pattern that it builds itself. It supports five pseudorandom sequences and a fixed repeating word of 1 to 32 bits. While it hunts, it loads its reference history from the bits it receives. It counts how many bits in a row the reference predicts correctly. Once enough bits in a row match, it declares lock. From then on the reference runs freely from its own predictions, and every accepted bit is counted. Every bit that differs from the prediction is counted as an error.

The bit stream comes in through a valid/ready handshake. The checker never applies back-pressure: `in_ready` is held high, and a bit is consumed on every clock in which `in_valid` is high. A source can pace the stream or leave gaps by lowering `in_valid`. These gaps let the checker follow only the slots of a frame that carry test traffic.

Software clears the counters with an edge on a control pin. Six kinds of event latch into a status vector. Software clears that vector with a read strobe. An interrupt line reports every latched event whose mask bit is not set.

Top module: `bert_rx_checker`

## Requirements
- R1: `in_ready` is 1 in every cycle after reset, and a bit is taken on each rising clock edge where `in_valid` is 1.
- R2: While unlocked, the reference history is loaded with received bits. `sync_o` goes to 1 after the edge that accepts the 32nd consecutive bit matching the prediction. In repeat mode (`mode`=5, period `rep_len`+1), the prediction is the bit received one period earlier. On every change of `sync_o`, status bit 0 is set.
- R3: While locked, `bit_count` increases by one for each accepted bit. `err_count` increases by one for each accepted bit that differs from the prediction, and status bit 5 is set. While unlocked, neither counter moves.
- R4: The lock holds while a 64-bit window contains 5 or fewer errors. The window starts when lock is gained and restarts every 64 accepted bits. The 6th error inside one window drops `sync_o` at that bit's edge.
- R5: `err_count` stops at all ones and does not wrap. Status bit 3 is set on the edge where it reaches all ones.
- R6: `bit_count` wraps from all ones to zero, and status bit 4 is set on that edge.
- R7: Status bit 1 is set after 32 consecutive accepted zeros. Status bit 2 is set after 32 consecutive accepted ones. This holds whether or not the checker is locked.
- R8: A status bit stays set until a cycle with `stat_rd`=1 clears the vector. An event in that same cycle remains set.
- R9: `irq` is 1 exactly when some status bit is 1 and its `stat_mask` bit is 0.
- R10: A rising edge on `load_cnt` clears both counters. Holding `load_cnt` high does not clear them again.
- R11: The `mode` values 0 to 4 select recurrences that predict each bit as the XOR of two earlier received bits. Mode 0 uses bits n-6 and n-7. Mode 1 uses n-5 and n-9. Mode 2 uses n-9 and n-11. Mode 3 uses n-14 and n-15. Mode 4 uses n-3 and n-20. A sequence built on a different recurrence never locks.
- R12: A cycle with `in_valid`=0 changes neither the counters nor `sync_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received bit is present |
| in_ready | output | 1 | Always 1 |
| in_data | input | 1 | Received bit |
| mode | input | 3 | Pattern select: 0 to 4 pseudorandom, 5 repeat |
| rep_len | input | 5 | Repeat period minus one |
| load_cnt | input | 1 | Counter clear, acts on its rising edge |
| stat_mask | input | 6 | Interrupt mask, 1 blocks the source |
| stat_rd | input | 1 | Status read strobe, clears the latched vector |
| sync_o | output | 1 | Pattern lock |
| bit_count | output | CNT_W (32) | Bits counted while locked |
| err_count | output | ERR_W (24) | Errors counted while locked |
| status | output | 6 | Latched events: 0 sync change, 1 zeros, 2 ones, 3 error full, 4 bit wrap, 5 bit error |
| irq | output | 1 | Unmasked status pending |

## Verification
The bench drives a 4-bit repeating word whose lock bit can be computed exactly, and uses it to pin down the 32-match acquisition rule. Single bit flips inserted into that word test the counting, the window loss and the saturation logic, kept apart by how the errors are spaced. Pseudorandom streams from two recurrences confirm that lock follows the selected recurrence. Feeding the wrong recurrence must never lock. Long constant runs check the zeros and ones detectors, and include a run broken one bit short.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
  typedef enum logic [2:0] {
    PAT_P7  = 3'd0,
    PAT_P9  = 3'd1,
    PAT_P11 = 3'd2,
    PAT_P15 = 3'd3,
    PAT_P20 = 3'd4,
    PAT_REP = 3'd5
  } pat_mode_e;

  localparam int ST_N     = 6;
  localparam int ST_SYNC  = 0;
  localparam int ST_ZEROS = 1;
  localparam int ST_ONES  = 2;
  localparam int ST_EFULL = 3;
  localparam int ST_BWRAP = 4;
  localparam int ST_BERR  = 5;
endpackage

// File: rtl/bert_rx_refgen.sv
module bert_rx_refgen #(
  parameter int HIST_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       locked,
  input  logic       rx_bit,
  input  logic [2:0] mode,
  input  logic [4:0] rep_len,
  output logic       exp_bit
);
  import bert_rx_pkg::*;

  logic [HIST_W-1:0] hist;  // hist[0] holds the most recent bit

  always_comb begin
    case (pat_mode_e'(mode))
      PAT_P7:  exp_bit = hist[5]  ^ hist[6];
      PAT_P9:  exp_bit = hist[4]  ^ hist[8];
      PAT_P11: exp_bit = hist[8]  ^ hist[10];
      PAT_P15: exp_bit = hist[13] ^ hist[14];
      PAT_P20: exp_bit = hist[2]  ^ hist[19];
      default: exp_bit = hist[rep_len];
    endcase
  end

  // Hunting: learn from the line. Locked: run on own predictions.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else if (adv) hist <= {hist[HIST_W-2:0], locked ? exp_bit : rx_bit};
  end
endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync #(
  parameter int SYNC_RUN = 32,
  parameter int WIN      = 64,
  parameter int LOSS_ERR = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic mismatch,
  output logic locked,
  output logic chg
);
  localparam int RUN_W = $clog2(SYNC_RUN);
  localparam int WIN_W = $clog2(WIN);
  localparam int LE_W  = $clog2(LOSS_ERR);

  logic [RUN_W-1:0] run_q, run_n;
  logic [WIN_W-1:0] win_q, win_n;
  logic [LE_W-1:0]  errs_q, errs_n;
  logic             lock_n;

  always_comb begin
    lock_n = locked;
    run_n  = run_q;
    win_n  = win_q;
    errs_n = errs_q;
    if (adv) begin
      if (!locked) begin
        if (mismatch) begin
          run_n = '0;
        end else if (run_q == RUN_W'(SYNC_RUN - 1)) begin
          lock_n = 1'b1;
          run_n  = '0;
          win_n  = '0;
          errs_n = '0;
        end else begin
          run_n = run_q + 1'b1;
        end
      end else if (mismatch && errs_q == LE_W'(LOSS_ERR - 1)) begin
        lock_n = 1'b0;
        run_n  = '0;
      end else if (win_q == WIN_W'(WIN - 1)) begin
        win_n  = '0;
        errs_n = '0;
      end else begin
        win_n  = win_q + 1'b1;
        errs_n = errs_q + LE_W'(mismatch);
      end
    end
  end

  assign chg = (lock_n != locked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      run_q  <= '0;
      win_q  <= '0;
      errs_q <= '0;
    end else begin
      locked <= lock_n;
      run_q  <= run_n;
      win_q  <= win_n;
      errs_q <= errs_n;
    end
  end
endmodule

// File: rtl/bert_rx_counters.sv
module bert_rx_counters #(
  parameter int CNT_W = 32,
  parameter int ERR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             locked,
  input  logic             mismatch,
  input  logic             clr,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [ERR_W-1:0] err_cnt,
  output logic             bit_wrap,
  output logic             err_full
);
  localparam logic [CNT_W-1:0] BIT_MAX = '1;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic count_en;
  assign count_en = adv && locked && !clr;
  assign bit_wrap = count_en && (bit_cnt == BIT_MAX);
  assign err_full = count_en && mismatch && (err_cnt == ERR_MAX - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (clr) begin
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (count_en) begin
      bit_cnt <= bit_cnt + 1'b1;
      if (mismatch && err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bert_rx_status.sv
module bert_rx_status #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic            rd,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] status,
  output logic            irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (rd ? '0 : status) | ev;
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker #(
  parameter int CNT_W    = 32,
  parameter int ERR_W    = 24,
  parameter int SYNC_RUN = 32,
  parameter int WIN      = 64,
  parameter int LOSS_ERR = 6,
  parameter int ALL_RUN  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_data,
  input  logic [2:0]                   mode,
  input  logic [4:0]                   rep_len,
  input  logic                         load_cnt,
  input  logic [bert_rx_pkg::ST_N-1:0] stat_mask,
  input  logic                         stat_rd,
  output logic                         sync_o,
  output logic [CNT_W-1:0]             bit_count,
  output logic [ERR_W-1:0]             err_count,
  output logic [bert_rx_pkg::ST_N-1:0] status,
  output logic                         irq
);
  import bert_rx_pkg::*;

  localparam int AR_W = $clog2(ALL_RUN + 1);

  logic exp_bit, mismatch, sync_chg, bit_wrap, err_full, load_q, clr;
  logic zero_ev, one_ev;
  logic [AR_W-1:0] zrun, orun;
  logic [ST_N-1:0] ev;

  assign in_ready = 1'b1;
  assign mismatch = in_data ^ exp_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= load_cnt;
  end
  assign clr = load_cnt && !load_q;

  bert_rx_refgen #(.HIST_W(32)) u_ref (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .locked(sync_o),
    .rx_bit(in_data), .mode(mode), .rep_len(rep_len), .exp_bit(exp_bit)
  );

  bert_rx_sync #(.SYNC_RUN(SYNC_RUN), .WIN(WIN), .LOSS_ERR(LOSS_ERR)) u_sync (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .mismatch(mismatch),
    .locked(sync_o), .chg(sync_chg)
  );

  bert_rx_counters #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .locked(sync_o),
    .mismatch(mismatch), .clr(clr), .bit_cnt(bit_count), .err_cnt(err_count),
    .bit_wrap(bit_wrap), .err_full(err_full)
  );

  // Constant-level run detectors, independent of lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun <= '0;
      orun <= '0;
    end else if (in_valid) begin
      if (in_data) begin
        zrun <= '0;
        if (orun != AR_W'(ALL_RUN)) orun <= orun + 1'b1;
      end else begin
        orun <= '0;
        if (zrun != AR_W'(ALL_RUN)) zrun <= zrun + 1'b1;
      end
    end
  end
  assign zero_ev = in_valid && !in_data && (zrun == AR_W'(ALL_RUN - 1));
  assign one_ev  = in_valid &&  in_data && (orun == AR_W'(ALL_RUN - 1));

  always_comb begin
    ev           = '0;
    ev[ST_SYNC]  = sync_chg;
    ev[ST_ZEROS] = zero_ev;
    ev[ST_ONES]  = one_ev;
    ev[ST_EFULL] = err_full;
    ev[ST_BWRAP] = bit_wrap;
    ev[ST_BERR]  = in_valid && sync_o && mismatch;
  end

  bert_rx_status #(.NSRC(ST_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev), .rd(stat_rd), .mask(stat_mask),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/bert_rx_sva.sv
module bert_rx_sva #(
  parameter int CNT_W = 32,
  parameter int ERR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             load_cnt,
  input logic [5:0]       stat_mask,
  input logic             stat_rd,
  input logic             sync_o,
  input logic [CNT_W-1:0] bit_count,
  input logic [ERR_W-1:0] err_count,
  input logic [5:0]       status,
  input logic             irq
);
  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  a_r2_lock_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> (status[0] && $past(in_valid)));

  a_r4_loss_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_o) |-> (status[0] && $past(in_valid)));

  a_r3_frozen_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sync_o && !load_cnt) |=> ($stable(err_count) && $stable(bit_count)));

  a_r5_err_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((&err_count) && !load_cnt) |=> (&err_count));

  a_r6_bit_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sync_o && (&bit_count) && !load_cnt) |=> (bit_count == '0 && status[4]));

  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status)) == $past(status)));

  a_r9_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&stat_mask) |-> !irq);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !load_cnt) |=> ($stable(bit_count) && $stable(err_count) && $stable(sync_o)));
endmodule

bind bert_rx_checker bert_rx_sva #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .load_cnt(load_cnt), .stat_mask(stat_mask), .stat_rd(stat_rd),
  .sync_o(sync_o), .bit_count(bit_count), .err_count(err_count),
  .status(status), .irq(irq)
);

// File: tb/bert_rx_checker_bench.sv
`timescale 1ns/1ps
module bert_rx_checker_bench;
  localparam int CNT_W = 8;
  localparam int ERR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_data = 1'b0, load_cnt = 1'b0, stat_rd = 1'b0;
  logic [2:0] mode = 3'd5;
  logic [4:0] rep_len = 5'd3;
  logic [5:0] stat_mask = 6'h3F;
  logic in_ready, sync_o, irq;
  logic [CNT_W-1:0] bit_count;
  logic [ERR_W-1:0] err_count;
  logic [5:0] status;

  int checks = 0;
  int fails = 0;
  int rp = 0;
  logic [31:0] ph = '1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bert_rx_checker #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_bert_rx_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mode(mode), .rep_len(rep_len), .load_cnt(load_cnt),
    .stat_mask(stat_mask), .stat_rd(stat_rd), .sync_o(sync_o),
    .bit_count(bit_count), .err_count(err_count), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; load_cnt = 1'b0; stat_rd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rp = 0;
    ph = '1;
  endtask

  // Called at a negedge; the bit is taken at the next posedge
  task automatic send(input logic b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic rep_next();
    logic b;
    b  = ((rp % 4) < 2);  // word 1,1,0,0 repeating
    rp = rp + 1;
    return b;
  endfunction

  task automatic good(input int n);
    for (int i = 0; i < n; i++) send(rep_next());
  endtask

  task automatic bad(input int n);
    for (int i = 0; i < n; i++) send(~rep_next());
  endtask

  task automatic prbs(input int n, input int ta, input int tb);
    for (int i = 0; i < n; i++) begin
      logic b;
      b  = ph[ta] ^ ph[tb];
      ph = {ph[30:0], b};
      send(b);
    end
  endtask

  task automatic rd_status();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic lock_rep();
    do_reset();
    mode = 3'd5; rep_len = 5'd3;
    good(34);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ready", in_ready, 1);
    chk("R2 sync after reset", sync_o, 0);
    chk("R3 bits after reset", bit_count, 0);
    chk("R3 errs after reset", err_count, 0);
    chk("R8 status after reset", status, 0);
    chk("R9 irq after reset", irq, 0);
  endtask

  task automatic t_acquire();
    do_reset();
    mode = 3'd5; rep_len = 5'd3;
    good(33);
    chk("R2 no lock at 33", sync_o, 0);
    good(1);
    chk("R2 lock at 34", sync_o, 1);
    chk("R2 sync status", status[0], 1);
    chk("R3 nothing counted yet", bit_count, 0);
  endtask

  task automatic t_errors();
    lock_rep();
    good(10); bad(1); good(5); bad(1); good(5); bad(1);
    chk("R3 error count", err_count, 3);
    chk("R3 bit count", bit_count, 23);
    chk("R3 still locked", sync_o, 1);
    chk("R3 error status", status[5], 1);
  endtask

  task automatic t_loss();
    lock_rep();
    bad(5);
    chk("R4 five errors keep lock", sync_o, 1);
    bad(1);
    chk("R4 sixth error drops lock", sync_o, 0);
    chk("R4 errors counted", err_count, 6);
    good(3);
    chk("R3 frozen after loss bits", bit_count, 6);
    chk("R3 frozen after loss errs", err_count, 6);
    lock_rep();
    bad(5); good(59); bad(1);
    chk("R4 new window keeps lock", sync_o, 1);
    chk("R4 window errors", err_count, 6);
  endtask

  task automatic t_saturate();
    lock_rep();
    for (int g = 0; g < 3; g++) begin bad(4); good(60); end
    chk("R5 twelve errors", err_count, 12);
    chk("R5 not full yet", status[3], 0);
    bad(3);
    chk("R5 reaches full", err_count, 15);
    chk("R5 full status", status[3], 1);
    bad(1);
    chk("R5 holds at full", err_count, 15);
  endtask

  task automatic t_wrap();
    lock_rep();
    good(255);
    chk("R6 at top", bit_count, 255);
    chk("R6 no wrap yet", status[4], 0);
    good(1);
    chk("R6 wrapped", bit_count, 0);
    chk("R6 wrap status", status[4], 1);
  endtask

  task automatic t_levels();
    do_reset();
    mode = 3'd5; rep_len = 5'd3;
    for (int i = 0; i < 31; i++) send(1'b0);
    chk("R7 31 zeros", status[1], 0);
    send(1'b0);
    chk("R7 32 zeros", status[1], 1);
    for (int i = 0; i < 20; i++) send(1'b1);
    send(1'b0);
    for (int i = 0; i < 31; i++) send(1'b1);
    chk("R7 broken ones run", status[2], 0);
    send(1'b1);
    chk("R7 32 ones", status[2], 1);
    rd_status();
    chk("R8 read clears", status, 0);
  endtask

  task automatic t_read_race();
    lock_rep();
    chk("R8 sticky sync bit", status[0], 1);
    stat_rd = 1'b1;
    bad(1);
    stat_rd = 1'b0;
    chk("R8 same-cycle event kept", status, 6'b100000);
  endtask

  task automatic t_irq();
    lock_rep();
    stat_mask = 6'h3F;
    #0.5;
    chk("R9 all masked", irq, 0);
    stat_mask = 6'h3E;
    #0.5;
    chk("R9 sync unmasked", irq, 1);
    stat_mask = 6'h1F;
    #0.5;
    chk("R9 other bit only", irq, 0);
    @(negedge clk);
    bad(1);
    chk("R9 error unmasked", irq, 1);
    stat_mask = 6'h3F;
  endtask

  task automatic t_load();
    lock_rep();
    good(10); bad(2); good(8);
    chk("R10 bits before", bit_count, 20);
    load_cnt = 1'b1;
    @(negedge clk);
    chk("R10 bits cleared", bit_count, 0);
    chk("R10 errs cleared", err_count, 0);
    good(5);
    chk("R10 held high no reclear", bit_count, 5);
    load_cnt = 1'b0;
    for (int i = 0; i < 10; i++) begin
      in_data = ~in_data;
      @(negedge clk);
    end
    chk("R12 idle bits", bit_count, 5);
    chk("R12 idle sync", sync_o, 1);
    chk("R1 ready idle", in_ready, 1);
  endtask

  task automatic t_prbs();
    do_reset();
    mode = 3'd0;
    prbs(200, 5, 6);
    chk("R11 mode0 locks", sync_o, 1);
    load_cnt = 1'b1;
    @(negedge clk);
    load_cnt = 1'b0;
    prbs(100, 5, 6);
    chk("R11 mode0 bits", bit_count, 100);
    chk("R11 mode0 errs", err_count, 0);
    do_reset();
    mode = 3'd3;
    prbs(400, 13, 14);
    chk("R11 mode3 locks", sync_o, 1);
    do_reset();
    mode = 3'd1;
    prbs(300, 5, 6);
    chk("R11 wrong recurrence", sync_o, 0);
  endtask

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_acquire();
    t_errors();
    t_loss();
    t_saturate();
    t_wrap();
    t_levels();
    t_read_race();
    t_irq();
    t_load();
    t_prbs();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule